// File: doc/BRIEF.md
# Period Timer with Vectored Shared Interrupt

This block is a 16-bit timer that counts upward from zero to a period limit and then starts again at zero. The period limit is held in compare slot 0, so one full cycle lasts that value plus one counts. The count advances on an external clock-enable pulse. A prescaler can slow it further by 1, 2, 4 or 8. A control write can zero both the counter and the prescaler.

Compare slot 0 drives its own interrupt line, which has the higher priority. A hardware acknowledge on that line clears its flag. The remaining compare slots and the wrap event share a second line. Their flags stay set until software clears them. Software can clear them in two ways. It can write ones to the flag register. It can also read the vector register, which returns a code for the most urgent enabled pending source and clears only that source's flag. If another enabled source is still pending after that read, the shared line stays asserted, so the handler can service sources one after another.

Software reaches the block through a simple register bus. Writes take effect on the clock edge. Read data is combinational from the address. A read strobe matters only for the vector register.

Top module: `vec_timer`

## Requirements
- R1: After reset the count, the flags, the enables, the control word and the vector code all read 0, and both interrupt outputs are low.
- R2: Each count tick moves the counter up by one. When the counter equals the compare 0 value, the next tick returns it to 0, so the period is compare 0 plus one ticks.
- R3: Control bits [1:0] set the prescaler: code 0 gives one tick per enabled clock, 1 gives one per 2, 2 gives one per 4, and 3 gives one per 8. Control bit 2 lets the timer run.
- R4: Writing control bit 3 as 1 zeroes the counter and the prescaler phase on that edge, whatever else is happening.
- R5: The flag of compare slot i (flag register bit i) sets on the tick that brings the counter to that slot's compare value.
- R6: The wrap flag (flag register bit 15) sets on the tick that takes the counter from the compare 0 value back to 0.
- R7: The dedicated interrupt output is high exactly while flag 0 and its enable (enable register bit 0) are both set. An acknowledge pulse clears flag 0.
- R8: An acknowledge leaves the flags of the other slots and the wrap flag unchanged.
- R9: The vector register reads 0 when nothing is pending, 2 for slot 1, 4 for slot 2 and 10 for wrap. Only enabled flags count. Lower slot numbers win, and wrap has the lowest priority. The shared output is high exactly when this code is not 0.
- R10: A strobed read of the vector register clears only the flag it reported. If another enabled flag is still set, the shared output stays high.
- R11: A disabled flag still sets, but it raises no request and does not appear in the vector register.
- R12: Writing the flag register clears each flag whose bit is written as 1 and leaves the other flags alone.
- R13: When the clock enable is low, or the run bit is 0, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Count enable pulse feeding the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on the vector register only) |
| reg_addr | input | 4 | Register address: 0 control, 1 count, 2 enables, 3 flags, 4 vector, 8+i compare i |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| irq_cc0 | output | 1 | Dedicated request of compare slot 0 |
| irq_cc0_ack | input | 1 | Acknowledge of the dedicated request; clears flag 0 |
| irq_shared | output | 1 | Shared request of the other slots and the wrap event |

## Verification
The hardest state to reach is the one where every shared source is pending at once, while some of them are disabled. Only then can the priority order and the read-to-clear behaviour be observed one step at a time. The bench reaches it by gating the clock enable: it lets exactly one full period of ticks through, so slots 1 and 2, slot 0 and the wrap event all set in a known order. It then stops the counter. It reads the vector register repeatedly, toggling enables between reads, and checks which flag has gone after each read. A separate sweep over every divider code, several period limits and every elapsed cycle count checks the count and the flag timing against arithmetic on the elapsed time.

// File: rtl/vt_pkg.sv
package vt_pkg;

  typedef enum logic [1:0] {
    DIV1 = 2'd0,
    DIV2 = 2'd1,
    DIV4 = 2'd2,
    DIV8 = 2'd3
  } div_e;

  localparam int PRE_W = 3;

  localparam logic [3:0] VEC_NONE = 4'd0;
  localparam logic [3:0] VEC_WRAP = 4'd10;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_COUNT = 1;
  localparam int ADR_IEN   = 2;
  localparam int ADR_IFLAG = 3;
  localparam int ADR_VEC   = 4;
  localparam int ADR_CMP   = 8;

  localparam int CTRL_RUN_BIT = 2;
  localparam int CTRL_CLR_BIT = 3;

endpackage

// File: rtl/vt_prescaler.sv
module vt_prescaler
  import vt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clk_en,
  input  logic clr,
  input  div_e div,
  output logic tick
);

  logic [PRE_W-1:0] phase_q, phase_d, limit;

  always_comb begin
    unique case (div)
      DIV1:    limit = PRE_W'(0);
      DIV2:    limit = PRE_W'(1);
      DIV4:    limit = PRE_W'(3);
      default: limit = PRE_W'(7);
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    tick    = 1'b0;
    if (clr) begin
      phase_d = '0;
    end else if (run && clk_en) begin
      if (phase_q >= limit) begin
        phase_d = '0;
        tick    = 1'b1;
      end else begin
        phase_d = phase_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/vt_counter.sv
module vt_counter #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         clr,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]             cnt,
  output logic [NUM_CH-1:0]            hit,
  output logic                         wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             at_top;

  assign at_top = (cnt_q == cmp[0]);
  assign step   = at_top ? '0 : cnt_q + CNT_W'(1);
  assign wrap   = tick && at_top;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign hit[g] = tick && (step == cmp[g]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/vt_flags.sv
module vt_flags
  import vt_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_evt,
  input  logic [NUM_SRC-1:0] w1c,
  input  logic [NUM_SRC-1:0] en,
  input  logic               ack,
  input  logic               vec_rd,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq_ded,
  output logic               irq_shr,
  output logic [3:0]         vec_code
);

  localparam int WRAP_IDX = NUM_SRC - 1;

  logic [NUM_SRC-1:0] flg_q, flg_d, pend, sel, clr_all;

  assign pend = flg_q & en;

  always_comb begin
    sel      = '0;
    vec_code = VEC_NONE;
    if (pend[WRAP_IDX]) begin
      sel[WRAP_IDX] = 1'b1;
      vec_code      = VEC_WRAP;
    end
    for (int i = WRAP_IDX - 1; i >= 1; i--) begin
      if (pend[i]) begin
        sel      = '0;
        sel[i]   = 1'b1;
        vec_code = 4'(2 * i);
      end
    end
  end

  always_comb begin
    clr_all    = w1c | (vec_rd ? sel : '0);
    clr_all[0] = clr_all[0] | ack;
    flg_d      = (flg_q & ~clr_all) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags   = flg_q;
  assign irq_ded = pend[0];
  assign irq_shr = |pend[WRAP_IDX:1];

endmodule

// File: rtl/vec_timer.sv
module vec_timer
  import vt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3,
  parameter int ADR_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [ADR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_cc0,
  input  logic             irq_cc0_ack,
  output logic             irq_shared
);

  localparam int NUM_SRC = NUM_CH + 1;
  localparam int DAT_W   = CNT_W;

  div_e                         div_q, div_d;
  logic                         run_q, run_d;
  logic [NUM_SRC-1:0]           ien_q, ien_d;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q, cmp_d;

  logic               tick, clr, vec_rd, wrap;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_CH-1:0]  hit;
  logic [NUM_SRC-1:0] set_evt, w1c, flags;
  logic [3:0]         vec_code;

  function automatic logic [DAT_W-1:0] src2word(input logic [NUM_SRC-1:0] s);
    logic [DAT_W-1:0] w;
    w            = '0;
    w[NUM_CH-1:0] = s[NUM_CH-1:0];
    w[DAT_W-1]   = s[NUM_CH];
    return w;
  endfunction

  function automatic logic [NUM_SRC-1:0] word2src(input logic [DAT_W-1:0] w);
    return {w[DAT_W-1], w[NUM_CH-1:0]};
  endfunction

  assign clr     = reg_wr && (reg_addr == ADR_W'(ADR_CTRL)) && reg_wdata[CTRL_CLR_BIT];
  assign vec_rd  = reg_rd && (reg_addr == ADR_W'(ADR_VEC));
  assign w1c     = (reg_wr && (reg_addr == ADR_W'(ADR_IFLAG))) ? word2src(reg_wdata) : '0;
  assign set_evt = {wrap, hit};

  always_comb begin
    div_d = div_q;
    run_d = run_q;
    ien_d = ien_q;
    cmp_d = cmp_q;
    if (reg_wr) begin
      if (reg_addr == ADR_W'(ADR_CTRL)) begin
        div_d = div_e'(reg_wdata[1:0]);
        run_d = reg_wdata[CTRL_RUN_BIT];
      end
      if (reg_addr == ADR_W'(ADR_IEN)) ien_d = word2src(reg_wdata);
      for (int i = 0; i < NUM_CH; i++) begin
        if (reg_addr == ADR_W'(ADR_CMP + i)) cmp_d[i] = reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV1;
      run_q <= 1'b0;
      ien_q <= '0;
      cmp_q <= '0;
    end else begin
      div_q <= div_d;
      run_q <= run_d;
      ien_q <= ien_d;
      cmp_q <= cmp_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_W'(ADR_CTRL)) begin
      reg_rdata[1:0]          = div_q;
      reg_rdata[CTRL_RUN_BIT] = run_q;
    end
    if (reg_addr == ADR_W'(ADR_COUNT)) reg_rdata = cnt;
    if (reg_addr == ADR_W'(ADR_IEN))   reg_rdata = src2word(ien_q);
    if (reg_addr == ADR_W'(ADR_IFLAG)) reg_rdata = src2word(flags);
    if (reg_addr == ADR_W'(ADR_VEC))   reg_rdata = DAT_W'(vec_code);
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ADR_W'(ADR_CMP + i)) reg_rdata = cmp_q[i];
    end
  end

  vt_prescaler i_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .clk_en (clk_en),
    .clr    (clr),
    .div    (div_q),
    .tick   (tick)
  );

  vt_counter #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .clr   (clr),
    .cmp   (cmp_q),
    .cnt   (cnt),
    .hit   (hit),
    .wrap  (wrap)
  );

  vt_flags #(.NUM_SRC(NUM_SRC)) i_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .w1c      (w1c),
    .en       (ien_q),
    .ack      (irq_cc0_ack),
    .vec_rd   (vec_rd),
    .flags    (flags),
    .irq_ded  (irq_cc0),
    .irq_shr  (irq_shared),
    .vec_code (vec_code)
  );

endmodule

// File: rtl/vt_checker.sv
module vt_checker #(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               clr,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   top,
  input logic [NUM_SRC-1:0] set_evt,
  input logic [NUM_SRC-1:0] w1c,
  input logic [NUM_SRC-1:0] flags,
  input logic               ack,
  input logic               vec_rd,
  input logic [3:0]         vec_code,
  input logic               irq_ded,
  input logic               irq_shr
);

  localparam int WI = NUM_SRC - 1;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr && (cnt == top) |=> cnt == '0); // R2

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R4

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr |=> $stable(cnt)); // R13

  AST_ACK_DROPS_DED: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !set_evt[0] |=> !irq_ded); // R7

  AST_ACK_KEEPS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !vec_rd && (w1c == '0) |=>
      ((flags[WI:1] & $past(flags[WI:1])) == $past(flags[WI:1]))); // R8

  AST_SHARED_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shr == (vec_code != 4'd0)); // R9

  AST_VEC_READ_CLEARS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && (vec_code == 4'd10) && !set_evt[WI] && !clr |=> !flags[WI]); // R10

endmodule

bind vec_timer vt_checker #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .clr      (clr),
  .cnt      (cnt),
  .top      (cmp_q[0]),
  .set_evt  (set_evt),
  .w1c      (w1c),
  .flags    (flags),
  .ack      (irq_cc0_ack),
  .vec_rd   (vec_rd),
  .vec_code (vec_code),
  .irq_ded  (irq_cc0),
  .irq_shr  (irq_shared)
);

// File: tb/test_vec_timer.sv
module test_vec_timer;

  localparam int A_CTRL = 0, A_CNT = 1, A_IEN = 2, A_FLG = 3, A_VEC = 4, A_CMP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_cc0;
  logic        irq_cc0_ack = 1'b0;
  logic        irq_shared;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vec_timer i_vec_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en      (clk_en),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_cc0     (irq_cc0),
    .irq_cc0_ack (irq_cc0_ack),
    .irq_shared  (irq_shared)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    reg_addr  = 4'(a);
    reg_wdata = 16'(d);
    reg_wr    = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic peek(input int a, output int d);
    reg_addr = 4'(a);
    #2;
    d = int'(reg_rdata);
  endtask

  task automatic rd_vec(output int d);
    reg_addr = 4'(A_VEC);
    reg_rd   = 1'b1;
    #2;
    d = int'(reg_rdata);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int v;
    int cmps[4];
    cmps = '{0, 1, 3, 6};
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    peek(A_CNT, v);  chk("R1 count", v, 0);
    peek(A_FLG, v);  chk("R1 flags", v, 0);
    peek(A_IEN, v);  chk("R1 enables", v, 0);
    peek(A_CTRL, v); chk("R1 control", v, 0);
    peek(A_VEC, v);  chk("R1 vector", v, 0);
    chk("R1 irq_cc0", int'(irq_cc0), 0);
    chk("R1 irq_shared", int'(irq_shared), 0);

    // Sweep: R2 R3 R5 R6 R7 R11 over divider, period and elapsed cycles
    clk_en = 1'b1;
    for (int dv = 0; dv < 4; dv++) begin
      for (int ci = 0; ci < 4; ci++) begin
        for (int m = 0; m <= 20; m++) begin
          int p, c1, t, n, t0, t1;
          p  = cmps[ci];
          c1 = (p + 1) / 2;
          n  = 1 << dv;
          bus_wr(A_CTRL, dv | 8);
          bus_wr(A_CMP, p);
          bus_wr(A_CMP + 1, c1);
          bus_wr(A_CMP + 2, p + 2);
          bus_wr(A_IEN, 1);
          bus_wr(A_FLG, 16'hFFFF);
          bus_wr(A_CTRL, dv | 4 | 8);
          idle(m);
          t  = m / n;
          t0 = (p == 0) ? 1 : p;
          t1 = (c1 == 0) ? p + 1 : c1;
          peek(A_CNT, v);
          chk("R2 R3 count", v, t % (p + 1));
          peek(A_FLG, v);
          chk("R5 R6 flags", v, ((t >= t0) ? 1 : 0) | ((t >= t1) ? 2 : 0) |
                                ((t >= p + 1) ? 16'h8000 : 0));
          chk("R7 irq_cc0 follows flag 0", int'(irq_cc0), (t >= t0) ? 1 : 0);
          chk("R11 disabled sources stay quiet", int'(irq_shared), 0);
        end
      end
    end

    // Directed: all sources pending, then R7 R8 R9 R10 R11
    clk_en = 1'b0;
    bus_wr(A_CTRL, 8);
    bus_wr(A_CMP, 9);
    bus_wr(A_CMP + 1, 2);
    bus_wr(A_CMP + 2, 5);
    bus_wr(A_IEN, 16'h8007);
    bus_wr(A_FLG, 16'hFFFF);
    bus_wr(A_CTRL, 4 | 8);
    clk_en = 1'b1; idle(10); clk_en = 1'b0;
    peek(A_CNT, v); chk("R2 full period back to 0", v, 0);
    peek(A_FLG, v); chk("R5 R6 all flags set", v, 16'h8007);
    chk("R7 irq_cc0 high", int'(irq_cc0), 1);
    chk("R9 irq_shared high", int'(irq_shared), 1);

    irq_cc0_ack = 1'b1; @(posedge clk); #1; irq_cc0_ack = 1'b0;
    chk("R7 ack drops irq_cc0", int'(irq_cc0), 0);
    peek(A_FLG, v); chk("R8 ack spares shared flags", v, 16'h8006);

    bus_wr(A_IEN, 16'h8005);
    rd_vec(v); chk("R9 R11 disabled slot 1 skipped", v, 4);
    peek(A_FLG, v); chk("R10 only slot 2 cleared", v, 16'h8002);
    chk("R10 shared stays high", int'(irq_shared), 1);
    rd_vec(v); chk("R9 wrap code", v, 10);
    peek(A_FLG, v); chk("R10 wrap cleared", v, 2);
    chk("R11 disabled flag no request", int'(irq_shared), 0);
    rd_vec(v); chk("R9 none code", v, 0);
    peek(A_FLG, v); chk("R10 empty read clears nothing", v, 2);
    bus_wr(A_IEN, 16'h8007);
    chk("R9 enable exposes slot 1", int'(irq_shared), 1);
    rd_vec(v); chk("R9 slot 1 code", v, 2);
    peek(A_FLG, v); chk("R10 slot 1 cleared", v, 0);
    chk("R10 shared drops when empty", int'(irq_shared), 0);

    // R12: write-one-to-clear
    clk_en = 1'b1; idle(10); clk_en = 1'b0;
    peek(A_FLG, v); chk("R5 second period flags", v, 16'h8007);
    bus_wr(A_FLG, 4);
    peek(A_FLG, v); chk("R12 clear slot 2 only", v, 16'h8003);
    bus_wr(A_FLG, 16'h8000);
    peek(A_FLG, v); chk("R12 clear wrap only", v, 3);

    // R13: hold with clk_en low or run low
    clk_en = 1'b1; idle(3); clk_en = 1'b0;
    peek(A_CNT, v); chk("R2 three ticks", v, 3);
    idle(5);
    peek(A_CNT, v); chk("R13 clk_en low holds", v, 3);
    clk_en = 1'b1;
    bus_wr(A_CTRL, 0);
    idle(5);
    peek(A_CNT, v); chk("R13 run low holds", v, 4);

    // R4: clear resets the prescaler phase
    bus_wr(A_CTRL, 3 | 4 | 8);
    idle(5);
    bus_wr(A_CTRL, 3 | 4 | 8);
    idle(7);
    peek(A_CNT, v); chk("R4 R3 phase restarted (7)", v, 0);
    idle(1);
    peek(A_CNT, v); chk("R4 R3 phase restarted (8)", v, 1);
    peek(A_CTRL, v); chk("R3 control readback", v, 7);

    summary();
  end

endmodule